// File: doc/BRIEF.md
# Secure page ownership controller

This block is the only agent allowed to change guest-physical to machine page mappings in a virtualised system. The hypervisor still decides which machine pages a virtual machine receives, but it cannot write mapping tables or the table root itself. Instead it sends commands to this controller. The controller checks each command against its ownership record and either carries it out or refuses it. Guests use the same command port to confirm that a page they rely on is private to them, or to give up that privacy on purpose.

Commands arrive one at a time on a valid/ready port. Each command carries:
- an opcode,
- a requester flag (guest or hypervisor),
- a VM identifier,
- a guest page number,
- a machine page number.

The controller keeps three pieces of state: one owner entry per machine page, one mapping table per VM, and a record per VM holding whether it exists and its table root. Every command ends with a single-cycle response code.

When a page is released, the controller wipes it through a word-write port before it answers. It also drives the active table root for the core. That root changes only when a switch command names a VM.

Top module: `pgown_ctrl`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` is 0, `active_root` is 0, no zero-writes are issued, no VM exists and every machine page is free (owner value 0).
- R2: One command is in flight at a time. `cmd_ready` is low from the cycle after acceptance until the response. The response is a one-cycle `rsp_valid` pulse, and `cmd_ready` returns the cycle after it.
- R3: Opcodes are 0 create, 1 map, 2 unmap, 3 switch, 4 validate, 5 share. Codes 6 and 7 are answered with ABORT. Response codes are 0 OK, 1 ABORT, 2 PRIVATE, 3 SHARED.
- R4: Create succeeds only from the hypervisor, for an identifier other than 0 that does not yet exist. It marks the VM as existing and gives it an empty mapping table. Any other create returns ABORT.
- R5: A map of a machine page owned by a different VM, and not shared, returns ABORT and changes no state. A map to a guest page that is already mapped is also refused.
- R6: A map whose machine page number is below `PROT_PAGES` (the region holding the controller's own tables) returns ABORT.
- R7: A successful map (hypervisor only) stores the entry for that VM's guest page. If the machine page was free, it becomes private to that VM.
- R8: An unmap by the hypervisor of a page owned by the VM zeroes every word of the page before the response. Word w of page p is at address p*2^WORD_W+w. The unmap then removes the entry and frees the page, so another VM may map it afterwards. Unmap of an unmapped guest page returns ABORT.
- R9: A switch from the hypervisor loads `active_root` with the root recorded at create, which is vm*2^GPN_W. `active_root` changes on no other command and has no direct write path. A guest switch returns ABORT.
- R10: Validate is accepted only from a guest. It returns SHARED if the mapped page is shared, and PRIVATE if the page is owned by that VM. An unmapped page, or a hypervisor request, returns ABORT.
- R11: Share succeeds only when issued by the owning guest. After a share, the page reads as SHARED and other VMs may map it. A hypervisor share returns ABORT and leaves the page private.
- R12: Map, unmap, switch, validate and share that name a VM never created return ABORT and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command accepted when valid |
| cmd_op | input | 3 | Opcode |
| cmd_guest | input | 1 | 1 = guest request, 0 = hypervisor |
| cmd_vm | input | VM_IDW | VM identifier |
| cmd_gpn | input | GPN_W | Guest page number |
| cmd_mpn | input | MPN_W | Machine page number (map only) |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 2 | OK, ABORT, PRIVATE or SHARED |
| mem_zero_we | output | 1 | Write zero to page memory |
| mem_zero_addr | output | MPN_W+WORD_W | Word address of the zero-write |
| active_root | output | VM_IDW+GPN_W | Active mapping table root for the core |

## Verification
The bound checker watches several properties on every cycle:
- a response never coincides with readiness and lasts one cycle,
- every zero-write happens while a command is in flight and never lands in the protected region,
- the table root moves only on the edge just before an OK response.

Some behaviour depends on the history of the ownership and mapping tables, and only the bench scenarios can show it:
- that a map is refused when another VM owns the page,
- that exactly the four words of the released page are wiped before the unmap answers,
- that a page freed by unmap can be mapped again,
- that a hypervisor share leaves a page private while a guest share makes it shared.

// File: rtl/pgown_pkg.sv
package pgown_pkg;
  localparam logic [2:0] OP_CREATE   = 3'd0;
  localparam logic [2:0] OP_MAP      = 3'd1;
  localparam logic [2:0] OP_UNMAP    = 3'd2;
  localparam logic [2:0] OP_SWITCH   = 3'd3;
  localparam logic [2:0] OP_VALIDATE = 3'd4;
  localparam logic [2:0] OP_SHARE    = 3'd5;

  localparam logic [1:0] RSP_OK      = 2'd0;
  localparam logic [1:0] RSP_ABORT   = 2'd1;
  localparam logic [1:0] RSP_PRIVATE = 2'd2;
  localparam logic [1:0] RSP_SHARED  = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOKUP, S_UPDATE, S_CLEAR, S_RESPOND
  } pgo_state_e;
endpackage

// File: rtl/pgown_own_tbl.sv
module pgown_own_tbl #(
  parameter int VM_IDW = 2,
  parameter int MPN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MPN_W-1:0]  idx,
  output logic [VM_IDW-1:0] owner,
  output logic              shared,
  input  logic              wr_en,
  input  logic [VM_IDW-1:0] wr_owner,
  input  logic              wr_shared
);
  localparam int PAGES = 2 ** MPN_W;

  logic [VM_IDW-1:0] own_q [PAGES];
  logic [PAGES-1:0]  shr_q;

  assign owner  = own_q[idx];
  assign shared = shr_q[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < PAGES; p++) own_q[p] <= '0;
      shr_q <= '0;
    end else if (wr_en) begin
      own_q[idx] <= wr_owner;
      shr_q[idx] <= wr_shared;
    end
  end
endmodule

// File: rtl/pgown_map_tbl.sv
module pgown_map_tbl #(
  parameter int VM_IDW = 2,
  parameter int GPN_W  = 3,
  parameter int MPN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VM_IDW-1:0] vm,
  input  logic [GPN_W-1:0]  gpn,
  output logic              ent_valid,
  output logic [MPN_W-1:0]  ent_mpn,
  input  logic              wr_en,
  input  logic              wr_valid,
  input  logic [MPN_W-1:0]  wr_mpn,
  input  logic              wipe_vm
);
  localparam int IDX_W = VM_IDW + GPN_W;
  localparam int DEPTH = 2 ** IDX_W;
  localparam int GPAGES = 2 ** GPN_W;

  logic [MPN_W-1:0] mpn_mem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [IDX_W-1:0] idx;

  assign idx       = {vm, gpn};
  assign ent_valid = vld_q[idx];
  assign ent_mpn   = mpn_mem[idx];

  // payload: plain RAM, no reset
  always_ff @(posedge clk) begin
    if (wr_en && wr_valid) mpn_mem[idx] <= wr_mpn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (wipe_vm) begin
      for (int g = 0; g < GPAGES; g++) vld_q[{vm, GPN_W'(g)}] <= 1'b0;
    end else if (wr_en) begin
      vld_q[idx] <= wr_valid;
    end
  end
endmodule

// File: rtl/pgown_zeroer.sv
module pgown_zeroer #(
  parameter int MPN_W  = 4,
  parameter int WORD_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic [MPN_W-1:0]        page,
  output logic                    fin,
  output logic                    we,
  output logic [MPN_W+WORD_W-1:0] addr
);
  localparam logic [WORD_W-1:0] LAST = '1;

  logic [WORD_W-1:0] cnt;

  assign fin = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      we   <= 1'b0;
      addr <= '0;
    end else begin
      we   <= run;
      addr <= {page, cnt};
      cnt  <= run ? cnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/pgown_ctrl.sv
module pgown_ctrl
  import pgown_pkg::*;
#(
  parameter int VM_IDW     = 2,
  parameter int GPN_W      = 3,
  parameter int MPN_W      = 4,
  parameter int WORD_W     = 2,
  parameter int PROT_PAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [2:0]               cmd_op,
  input  logic                     cmd_guest,
  input  logic [VM_IDW-1:0]        cmd_vm,
  input  logic [GPN_W-1:0]         cmd_gpn,
  input  logic [MPN_W-1:0]         cmd_mpn,
  output logic                     rsp_valid,
  output logic [1:0]               rsp_code,
  output logic                     mem_zero_we,
  output logic [MPN_W+WORD_W-1:0]  mem_zero_addr,
  output logic [VM_IDW+GPN_W-1:0]  active_root
);
  localparam int NVM = 2 ** VM_IDW;
  localparam int ROOT_W = VM_IDW + GPN_W;
  localparam logic [MPN_W-1:0] PROT_LIM = MPN_W'(PROT_PAGES);

  pgo_state_e st;
  logic [2:0]        c_op;
  logic              c_guest;
  logic [VM_IDW-1:0] c_vm;
  logic [GPN_W-1:0]  c_gpn;
  logic [MPN_W-1:0]  c_mpn;
  logic [1:0]        code_q;
  logic [NVM-1:0]    live_q;
  logic [ROOT_W-1:0] root_tab [NVM];

  logic              ent_v, shr, zfin, exists;
  logic [MPN_W-1:0]  ent_mpn, look_mpn;
  logic [VM_IDW-1:0] own;
  logic              in_upd;
  logic              map_wr, own_wr, own_wr_shared;
  logic [VM_IDW-1:0] own_wr_val;
  logic [1:0]        dec_code;
  pgo_state_e        dec_next;

  assign cmd_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESPOND);
  assign rsp_code  = code_q;
  assign exists    = live_q[c_vm];
  assign look_mpn  = (c_op == OP_MAP) ? c_mpn : ent_mpn;
  assign in_upd    = (st == S_UPDATE);

  pgown_map_tbl #(.VM_IDW(VM_IDW), .GPN_W(GPN_W), .MPN_W(MPN_W)) u_map (
    .clk(clk), .rst(rst), .vm(c_vm), .gpn(c_gpn),
    .ent_valid(ent_v), .ent_mpn(ent_mpn),
    .wr_en(map_wr), .wr_valid(c_op == OP_MAP), .wr_mpn(c_mpn),
    .wipe_vm(in_upd && c_op == OP_CREATE)
  );

  pgown_own_tbl #(.VM_IDW(VM_IDW), .MPN_W(MPN_W)) u_own (
    .clk(clk), .rst(rst), .idx(look_mpn), .owner(own), .shared(shr),
    .wr_en(own_wr), .wr_owner(own_wr_val), .wr_shared(own_wr_shared)
  );

  pgown_zeroer #(.MPN_W(MPN_W), .WORD_W(WORD_W)) u_zero (
    .clk(clk), .rst(rst), .run(st == S_CLEAR), .page(look_mpn),
    .fin(zfin), .we(mem_zero_we), .addr(mem_zero_addr)
  );

  // table writes, all in UPDATE
  always_comb begin
    map_wr        = in_upd && (c_op == OP_MAP || c_op == OP_UNMAP);
    own_wr        = in_upd && (c_op == OP_MAP || c_op == OP_UNMAP || c_op == OP_SHARE);
    own_wr_val    = own;
    own_wr_shared = shr;
    case (c_op)
      OP_MAP:   if (own == '0) begin own_wr_val = c_vm; own_wr_shared = 1'b0; end
      OP_UNMAP: if (own == c_vm) begin own_wr_val = '0; own_wr_shared = 1'b0; end
      OP_SHARE: own_wr_shared = 1'b1;
      default:  ;
    endcase
  end

  // decision taken in LOOKUP
  always_comb begin
    dec_code = RSP_ABORT;
    dec_next = S_RESPOND;
    case (c_op)
      OP_CREATE:
        if (!c_guest && c_vm != '0 && !exists) begin
          dec_code = RSP_OK; dec_next = S_UPDATE;
        end
      OP_MAP:
        if (!c_guest && exists && c_mpn >= PROT_LIM && !ent_v &&
            (own == '0 || own == c_vm || shr)) begin
          dec_code = RSP_OK; dec_next = S_UPDATE;
        end
      OP_UNMAP:
        if (!c_guest && exists && ent_v) begin
          dec_code = RSP_OK;
          dec_next = (own == c_vm) ? S_CLEAR : S_UPDATE;
        end
      OP_SWITCH:
        if (!c_guest && exists) begin
          dec_code = RSP_OK; dec_next = S_UPDATE;
        end
      OP_VALIDATE:
        if (c_guest && exists && ent_v) begin
          if (shr) dec_code = RSP_SHARED;
          else if (own == c_vm) dec_code = RSP_PRIVATE;
        end
      OP_SHARE:
        if (c_guest && exists && ent_v && own == c_vm) begin
          dec_code = RSP_OK; dec_next = S_UPDATE;
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      c_op        <= '0;
      c_guest     <= 1'b0;
      c_vm        <= '0;
      c_gpn       <= '0;
      c_mpn       <= '0;
      code_q      <= RSP_OK;
      live_q      <= '0;
      active_root <= '0;
      for (int v = 0; v < NVM; v++) root_tab[v] <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (cmd_valid) begin
            c_op <= cmd_op; c_guest <= cmd_guest; c_vm <= cmd_vm;
            c_gpn <= cmd_gpn; c_mpn <= cmd_mpn;
            st <= S_LOOKUP;
          end
        S_LOOKUP: begin
          code_q <= dec_code;
          st     <= dec_next;
        end
        S_CLEAR:
          if (zfin) st <= S_UPDATE;
        S_UPDATE: begin
          if (c_op == OP_CREATE) begin
            live_q[c_vm]   <= 1'b1;
            root_tab[c_vm] <= {c_vm, {GPN_W{1'b0}}};
          end
          if (c_op == OP_SWITCH) active_root <= root_tab[c_vm];
          st <= S_RESPOND;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgown_ctrl_chk.sv
module pgown_ctrl_chk #(
  parameter int VM_IDW     = 2,
  parameter int GPN_W      = 3,
  parameter int MPN_W      = 4,
  parameter int WORD_W     = 2,
  parameter int PROT_PAGES = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cmd_ready,
  input logic                    rsp_valid,
  input logic [1:0]              rsp_code,
  input logic                    mem_zero_we,
  input logic [MPN_W+WORD_W-1:0] mem_zero_addr,
  input logic [VM_IDW+GPN_W-1:0] active_root
);
  localparam logic [MPN_W-1:0] PROT_LIM = MPN_W'(PROT_PAGES);

  // R2: response and readiness are exclusive
  p_rsp_not_ready_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !cmd_ready);

  // R2: response lasts one cycle and readiness follows
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!rsp_valid && cmd_ready));

  // R8: page wipes only while a command is in flight
  p_zero_busy_r8: assert property (@(posedge clk) disable iff (rst)
    mem_zero_we |-> !cmd_ready);

  // R6: the protected region is never wiped
  p_zero_prot_r6: assert property (@(posedge clk) disable iff (rst)
    mem_zero_we |-> (mem_zero_addr[MPN_W+WORD_W-1:WORD_W] >= PROT_LIM));

  // R9: root moves only right before an OK response
  p_root_move_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_root) |-> (rsp_valid && rsp_code == 2'd0));

  // R1: reset state
  always_ff @(posedge clk) begin
    if (!rst && $past(rst)) begin
      p_reset_state_r1: assert (cmd_ready && !rsp_valid && !mem_zero_we && active_root == '0);
    end
  end
endmodule

bind pgown_ctrl pgown_ctrl_chk #(
  .VM_IDW(VM_IDW), .GPN_W(GPN_W), .MPN_W(MPN_W),
  .WORD_W(WORD_W), .PROT_PAGES(PROT_PAGES)
) u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .rsp_code(rsp_code), .mem_zero_we(mem_zero_we),
  .mem_zero_addr(mem_zero_addr), .active_root(active_root)
);

// File: tb/pgown_ctrl_test.sv
`timescale 1ns/1ps
module pgown_ctrl_test;
  localparam logic [1:0] OK = 2'd0, AB = 2'd1, PRV = 2'd2, SHR = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic cmd_guest = 1'b0;
  logic [1:0] cmd_vm = '0;
  logic [2:0] cmd_gpn = '0;
  logic [3:0] cmd_mpn = '0;
  logic rsp_valid;
  logic [1:0] rsp_code;
  logic mem_zero_we;
  logic [5:0] mem_zero_addr;
  logic [4:0] active_root;

  int n_chk = 0, n_fail = 0, n_zw = 0;
  bit finished = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];
  logic [3:0] zmask [16];

  always #4 clk = ~clk;

  pgown_ctrl uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_guest(cmd_guest), .cmd_vm(cmd_vm),
    .cmd_gpn(cmd_gpn), .cmd_mpn(cmd_mpn), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .mem_zero_we(mem_zero_we),
    .mem_zero_addr(mem_zero_addr), .active_root(active_root)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each response, records zero-writes
  always @(negedge clk) begin
    if (!rst && mem_zero_we) begin
      zmask[mem_zero_addr[5:2]][mem_zero_addr[1:0]] = 1'b1;
      n_zw++;
    end
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected response", rsp_code, -1);
      else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_code == e, t, rsp_code, e);
      end
    end
  end

  task automatic send(input logic [2:0] op, input logic g, input int vm, input int gpn,
                      input int mpn, input logic [1:0] exp, input string tag);
    @(negedge clk);
    cmd_op = op; cmd_guest = g; cmd_vm = 2'(vm); cmd_gpn = 3'(gpn); cmd_mpn = 4'(mpn);
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R2 busy after accept", cmd_ready, 0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 16; p++) zmask[p] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(active_root == 5'd0, "R1 root", active_root, 0);

    // R12: commands naming an uncreated VM
    send(3'd1, 0, 1, 0, 5, AB, "R12 map uncreated");
    send(3'd3, 0, 2, 0, 0, AB, "R12 switch uncreated");
    chk(active_root == 5'd0, "R12 root unchanged", active_root, 0);
    send(3'd4, 1, 1, 0, 0, AB, "R12 validate uncreated");

    // R3: undefined opcodes
    send(3'd6, 0, 1, 0, 0, AB, "R3 opcode 6");
    send(3'd7, 0, 1, 0, 0, AB, "R3 opcode 7");

    // R4: creation rules
    send(3'd0, 0, 0, 0, 0, AB, "R4 create id 0");
    send(3'd0, 1, 1, 0, 0, AB, "R4 create by guest");
    send(3'd0, 0, 1, 0, 0, OK, "R4 create vm1");
    send(3'd0, 0, 1, 0, 0, AB, "R4 create twice");
    send(3'd0, 0, 2, 0, 0, OK, "R4 create vm2");
    send(3'd4, 1, 1, 0, 0, AB, "R4 fresh table empty");

    // R7 / R10: map and validate
    send(3'd1, 1, 1, 0, 5, AB, "R7 map by guest");
    send(3'd1, 0, 1, 0, 5, OK, "R7 map vm1 g0->m5");
    send(3'd4, 1, 1, 0, 0, PRV, "R7 validate private");
    send(3'd4, 0, 1, 0, 0, AB, "R10 validate by hypervisor");
    send(3'd1, 0, 1, 0, 6, AB, "R5 remap mapped gpn");

    // R5: page owned by another VM
    send(3'd1, 0, 2, 0, 5, AB, "R5 map foreign page");
    send(3'd4, 1, 2, 0, 0, AB, "R5 no entry written");
    send(3'd4, 1, 1, 0, 0, PRV, "R5 owner kept");

    // R6: protected region
    send(3'd1, 0, 2, 1, 1, AB, "R6 map page 1");
    send(3'd1, 0, 2, 1, 0, AB, "R6 map page 0");
    send(3'd4, 1, 2, 1, 0, AB, "R6 no entry written");

    // R11: sharing
    send(3'd5, 0, 1, 0, 0, AB, "R11 share by hypervisor");
    send(3'd4, 1, 1, 0, 0, PRV, "R11 still private");
    send(3'd5, 1, 2, 0, 0, AB, "R11 share by non-owner");
    send(3'd5, 1, 1, 0, 0, OK, "R11 share by owner");
    send(3'd4, 1, 1, 0, 0, SHR, "R10 validate shared");
    send(3'd1, 0, 2, 2, 5, OK, "R11 map shared page");
    send(3'd4, 1, 2, 2, 0, SHR, "R11 second VM sees shared");

    // R8: unmap wipes page
    send(3'd1, 0, 2, 3, 9, OK, "R8 map vm2 g3->m9");
    for (int p = 0; p < 16; p++) zmask[p] = '0;
    n_zw = 0;
    send(3'd2, 0, 2, 3, 0, OK, "R8 unmap");
    chk(zmask[9] == 4'hF, "R8 all words zeroed", zmask[9], 15);
    chk(n_zw == 4, "R8 zero-write count", n_zw, 4);
    send(3'd4, 1, 2, 3, 0, AB, "R8 entry removed");
    send(3'd2, 0, 2, 3, 0, AB, "R8 unmap unmapped");
    send(3'd1, 0, 1, 1, 9, OK, "R8 freed page reusable");
    send(3'd4, 1, 1, 1, 0, PRV, "R8 new owner private");
    chk(n_zw == 4, "R8 no stray writes", n_zw, 4);

    // R9: switch
    send(3'd3, 0, 2, 0, 0, OK, "R9 switch vm2");
    chk(active_root == 5'd16, "R9 root vm2", active_root, 16);
    send(3'd3, 0, 1, 0, 0, OK, "R9 switch vm1");
    chk(active_root == 5'd8, "R9 root vm1", active_root, 8);
    send(3'd3, 1, 2, 0, 0, AB, "R9 switch by guest");
    chk(active_root == 5'd8, "R9 root held", active_root, 8);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule